// File: doc/BRIEF.md
# Port Timestamp and Timed Output Unit

This unit serves one group of I/O pins. It keeps a free-running port counter, advanced by a prescaler from the reference clock, and the counter is usually 16 bits wide. When a chosen edge appears on any input pin, the unit records the counter value. It also records a flag that tells software whether the counter wrapped since the previous record, so software can extend the timestamp to a wider count. A second record taken before software reads the first marks an overrun and keeps the newer value.

On the output side, software loads a target count and then writes the output data, and that write arms a single pending change. The output pins take the new data one reference clock after the counter first equals the target. Because the target is an absolute port time, software can time a reply exactly against the moment it captured a stimulus. Software reaches everything through a small register port. Writes go to control (address 0), target time (address 1) and output data (address 3). Reads return control (0), the capture value (1), status (2) and the live counter (3).

Top module: `ptime_unit`

## Requirements
- R1: The port counter is 0 after reset and advances by exactly one every D+1 reference clocks. D is the divider in control bits [15:8], and the counter wraps modulo 2^CNT_W. Address 3 reads the counter.
- R2: A selected input edge at a clock edge stores the counter value that holds after that clock edge. The record reads back at address 1, and status bit 0 (valid) is then 1.
- R3: Control bits [1:0] select the capture edge: 0 captures nothing, 1 captures rising edges, 2 captures falling edges and 3 captures both. An edge on any pin of the group counts.
- R4: A pulse that lasts one reference clock is captured. In rising-edge mode the stored value is the count at the rising edge. In falling-edge mode the stored value is the count at the falling edge.
- R5: Status bit 2 holds a wrap flag taken together with each capture. It is 1 when the counter wrapped since the previous capture, and this includes a wrap in the same clock. An edge in the clock where the counter wraps to 0 stores 0 with the flag set.
- R6: A capture made while valid is still set raises status bit 1 (overrun) and keeps the newer value. A read of address 1 with rd_en high clears valid, overrun and the wrap flag.
- R7: A write to address 3 arms one pending output and sets status bit 3. The pins take the written data one reference clock after the counter first holds the target from address 1, and the pending bit clears at the same time.
- R8: The target is compared by equality modulo 2^CNT_W. A target numerically below the current count fires after the counter wraps.
- R9: A fired output is one-shot. The pins keep the value when the counter passes the target again, until software arms a new output.
- R10: After reset the output pins are 0, the status is 0 and the capture value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | PW | Sampled input pins of the group |
| pin_out | output | PW | Scheduled output pin values |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Read strobe; at address 1 it consumes the capture |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |

## Verification
The bench builds the unit with an 8-bit counter, so wraps happen within a few hundred clocks. It sweeps all four edge modes against a lone rise, a lone fall and a one-clock pulse. This tells apart which edges are honoured and which edge of a pulse supplies the stored count, and it shows that both-edge mode yields an overrun that keeps the newest value. The timing checks sweep prescaler settings and place captures well clear of a wrap and exactly on one. Scheduled outputs are placed ahead of the count, behind it across a wrap, and under a divided count rate. That last case separates firing on the first clock at the target from firing on a later one.

// File: rtl/ptime_pkg.sv
`timescale 1ns/1ps
package ptime_pkg;

    localparam int BUS_W = 16;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TIME = 2'd1,
        REG_STAT = 2'd2,
        REG_DATA = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic wrap;
        logic overrun;
        logic valid;
    } cap_flags_t;

    // True when the pin vector shows an edge the mode selects.
    function automatic logic edge_hit(edge_mode_e m, logic [31:0] cur, logic [31:0] prv);
        logic rise;
        logic fall;
        logic res;
        rise = |(cur & ~prv);
        fall = |(~cur & prv);
        case (m)
            EDGE_RISE: res = rise;
            EDGE_FALL: res = fall;
            EDGE_ANY:  res = rise | fall;
            default:   res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/ptime_timebase.sv
`timescale 1ns/1ps
module ptime_timebase #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);
    logic [DIV_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    assign tick    = (pre_q >= div);
    assign wrap    = tick && (cnt_q == '1);
    assign cnt     = cnt_q;
    assign cnt_nxt = cnt_q + CNT_W'(tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end

    // R1
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

endmodule

// File: rtl/ptime_capture.sv
`timescale 1ns/1ps
module ptime_capture
    import ptime_pkg::*;
#(
    parameter int PW    = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    pin_in,
    input  logic [1:0]       mode,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] cap_val,
    output cap_flags_t       flags
);
    logic [PW-1:0]    prev_q;
    logic [CNT_W-1:0] cap_q;
    cap_flags_t       flags_q;
    logic             wrap_seen_q;
    logic             hit;

    assign hit     = edge_hit(edge_mode_e'(mode), 32'(pin_in), 32'(prev_q));
    assign cap_val = cap_q;
    assign flags   = flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= '0;
            cap_q       <= '0;
            flags_q     <= '0;
            wrap_seen_q <= 1'b0;
        end else begin
            prev_q <= pin_in;
            if (hit) begin
                cap_q           <= cnt_nxt;
                flags_q.valid   <= 1'b1;
                flags_q.overrun <= flags_q.valid && !rd_clr;
                flags_q.wrap    <= wrap_seen_q || wrap;
                wrap_seen_q     <= 1'b0;
            end else begin
                if (wrap)   wrap_seen_q <= 1'b1;
                if (rd_clr) flags_q     <= '0;
            end
        end
    end

    // R2
    capture_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> flags_q.valid);

    // R6
    second_capture_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && flags_q.valid && !rd_clr) |=> flags_q.overrun);

    // R6
    read_consumes_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !hit) |=> !flags_q.valid && !flags_q.overrun);

endmodule

// File: rtl/ptime_sched.sv
`timescale 1ns/1ps
module ptime_sched #(
    parameter int PW    = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tgt_we,
    input  logic [CNT_W-1:0] tgt_in,
    input  logic             arm_we,
    input  logic [PW-1:0]    data_in,
    output logic [PW-1:0]    pin_out,
    output logic             pending
);
    logic [CNT_W-1:0] tgt_q;
    logic [PW-1:0]    data_q;
    logic [PW-1:0]    out_q;
    logic             pend_q;
    logic             fire;

    assign fire    = pend_q && (cnt == tgt_q);
    assign pin_out = out_q;
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= '0;
            data_q <= '0;
            out_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (tgt_we) tgt_q <= tgt_in;
            if (fire)   out_q <= data_q;
            if (arm_we) begin
                data_q <= data_in;
                pend_q <= 1'b1;
            end else if (fire) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R9
    fire_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !arm_we) |=> !pend_q);

    // R7
    idle_output_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_q |=> $stable(out_q));

endmodule

// File: rtl/ptime_unit.sv
`timescale 1ns/1ps
module ptime_unit
    import ptime_pkg::*;
#(
    parameter int PW    = 4,
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    pin_in,
    output logic [PW-1:0]    pin_out,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [15:0]      wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [15:0]      rd_data
);
    localparam int DIV_LSB = 8;

    logic [1:0]       mode_q;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cap_val;
    cap_flags_t       flags;
    logic             pending;
    logic             rd_clr;
    logic             unused_ok;

    assign rd_clr    = rd_en && (reg_sel_e'(rd_addr) == REG_TIME);
    assign unused_ok = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            div_q  <= '0;
        end else if (wr_en && reg_sel_e'(wr_addr) == REG_CTRL) begin
            mode_q <= wr_data[1:0];
            div_q  <= wr_data[DIV_LSB +: DIV_W];
        end
    end

    ptime_timebase #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .div     (div_q),
        .tick    (tick),
        .wrap    (wrap),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    ptime_capture #(.PW(PW), .CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .mode    (mode_q),
        .wrap    (wrap),
        .cnt_nxt (cnt_nxt),
        .rd_clr  (rd_clr),
        .cap_val (cap_val),
        .flags   (flags)
    );

    ptime_sched #(.PW(PW), .CNT_W(CNT_W)) u_sch (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .tgt_we  (wr_en && reg_sel_e'(wr_addr) == REG_TIME),
        .tgt_in  (wr_data[CNT_W-1:0]),
        .arm_we  (wr_en && reg_sel_e'(wr_addr) == REG_DATA),
        .data_in (wr_data[PW-1:0]),
        .pin_out (pin_out),
        .pending (pending)
    );

    always_comb begin
        case (reg_sel_e'(rd_addr))
            REG_CTRL: rd_data = BUS_W'({div_q, 6'd0, mode_q});
            REG_TIME: rd_data = BUS_W'(cap_val);
            REG_STAT: rd_data = BUS_W'({pending, flags.wrap, flags.overrun, flags.valid});
            default:  rd_data = BUS_W'(cnt);
        endcase
    end

endmodule

// File: tb/sim_ptime_unit.sv
`timescale 1ns/1ps
module sim_ptime_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  pin_in = '0;
    logic [3:0]  pin_out;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    ptime_unit #(.PW(4), .CNT_W(8), .DIV_W(8)) u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_out(pin_out),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic clr_cap();
        rd_en = 1'b1; rd_addr = 2'd1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        int c;
        for (int i = 0; i < 700; i++) begin
            peek(2'd3, c);
            if (c == v) break;
            @(negedge clk);
        end
    endtask

    // kind 0: lone rise, 1: lone fall, 2: one-clock pulse (R3, R4, R6)
    task automatic edge_case(input int mode, input int kind);
        int b; int c; int st; int cap;
        int ev; int eo; int ec;
        b = (mode + kind) % 4;
        wr(2'd0, 16'(mode));
        if (kind == 1) begin
            pin_in[b] = 1'b1;
            @(negedge clk);
        end
        clr_cap();
        case (kind)
            0: begin pin_in[b] = 1'b1; @(negedge clk); end
            1: begin pin_in[b] = 1'b0; @(negedge clk); end
            default: begin
                pin_in[b] = 1'b1; @(negedge clk);
                pin_in[b] = 1'b0; @(negedge clk);
            end
        endcase
        peek(2'd3, c);
        peek(2'd2, st);
        peek(2'd1, cap);
        ev = 0; eo = 0; ec = 0;
        if (kind == 0 && mode[0]) begin ev = 1; ec = c; end
        if (kind == 1 && mode[1]) begin ev = 1; ec = c; end
        if (kind == 2) begin
            if (mode[1]) begin ev = 1; ec = c; eo = mode[0]; end
            else if (mode[0]) begin ev = 1; ec = (c - 1) & 255; end
        end
        chk(kind == 2 ? "R4 valid" : "R3 valid", st & 1, ev);
        chk("R6 overrun", (st >> 1) & 1, eo);
        if (ev == 1) chk(kind == 2 ? "R4 value" : "R2 value", cap, ec);
        pin_in = '0;
        @(negedge clk);
        clr_cap();
    endtask

    // R7, R8, R9: arm target t with data d, find the clock where pins change
    task automatic sched_case(input string req, input int t, input int d);
        int st; int r; int h1; int h2; int seen;
        wr(2'd1, 16'(t));
        wr(2'd3, 16'(d));
        peek(2'd2, st);
        chk("R7 pending set", (st >> 3) & 1, 1);
        peek(2'd3, h1);
        h2 = -1; seen = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            peek(2'd3, r);
            if (int'(pin_out) == d) begin seen = 1; break; end
            h2 = h1; h1 = r;
        end
        chk({req, " fired"}, seen, 1);
        chk({req, " count at target"}, h1, t);
        chk({req, " first clock at target"}, int'(h2 != t), 1);
        peek(2'd2, st);
        chk("R7 pending cleared", (st >> 3) & 1, 0);
    endtask

    initial begin
        int c0; int c1; int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 / R1 reset state
        chk("R10 pins", int'(pin_out), 0);
        peek(2'd2, v); chk("R10 status", v, 0);
        peek(2'd1, v); chk("R10 capture", v, 0);
        peek(2'd3, v); chk("R1 reset count", v, 0);

        // R1 prescaler sweep
        for (int d = 0; d < 4; d++) begin
            wr(2'd0, 16'(d << 8));
            peek(2'd3, c0);
            repeat ((d + 1) * 5) @(negedge clk);
            peek(2'd3, c1);
            chk("R1 rate", (c1 - c0) & 255, 5);
        end
        wr(2'd0, 16'h0000);

        // R3 / R4 / R6 edge-mode sweep
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 3; k++)
                edge_case(m, k);

        // R6 read clears
        wr(2'd0, 16'h0001);
        pin_in[2] = 1'b1; @(negedge clk);
        pin_in[2] = 1'b0; @(negedge clk);
        clr_cap();
        peek(2'd2, v); chk("R6 cleared", v & 7, 0);

        // R5 wrap flag
        wait_cnt(16);
        pin_in[0] = 1'b1; @(negedge clk);
        clr_cap(); pin_in = '0; @(negedge clk);
        wait_cnt(32);
        pin_in[0] = 1'b1; @(negedge clk);
        peek(2'd2, v); chk("R5 no wrap flag", (v >> 2) & 1, 0);
        clr_cap(); pin_in = '0; @(negedge clk);
        wait_cnt(255);
        pin_in[0] = 1'b1; @(negedge clk);
        peek(2'd1, v); chk("R5 value at wrap", v, 0);
        peek(2'd2, v); chk("R5 wrap flag", (v >> 2) & 1, 1);
        clr_cap(); pin_in = '0; @(negedge clk);
        repeat (300) @(negedge clk);
        pin_in[3] = 1'b1; @(negedge clk);
        peek(2'd3, c0);
        peek(2'd1, v); chk("R2 value", v, c0);
        peek(2'd2, v); chk("R5 elapsed wrap flag", (v >> 2) & 1, 1);
        clr_cap(); pin_in = '0; @(negedge clk);

        // R7 ahead of the count
        peek(2'd3, c0);
        sched_case("R7", (c0 + 40) & 255, 10);
        // R8 target behind the count, fires after wrap
        wait_cnt(240);
        sched_case("R8", 8, 5);
        // R9 one-shot: counter passes the target again
        repeat (300) @(negedge clk);
        chk("R9 pins hold", int'(pin_out), 5);
        wr(2'd1, 16'(8));
        repeat (300) @(negedge clk);
        chk("R9 target write alone", int'(pin_out), 5);
        // R7 under a divided count rate
        wr(2'd0, 16'h0200);
        peek(2'd3, c0);
        sched_case("R7 divided", (c0 + 10) & 255, 3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual 0 expected 1 (run incomplete)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule